// File: doc/BRIEF.md
# PCIe Receive Bandwidth Filter Counter

This block watches a stream of received transaction descriptors. Each descriptor gives a root-port index, a 16-bit requester ID (bus/device/function, for example 0x3900 for bus 0x39, device 0, function 0), a payload length in doublewords and a valid strobe. The block adds the payload size in bytes (length × 4) to a saturating accumulator, but only for packets that pass three filters.

The first filter is a target match. It selects either by a root-port bitmap or by an exact requester ID, never both at once. The second is a one-shot length trigger: counting begins on the first targeted packet whose length is above, or below, a power-of-two limit. The third is a per-packet length threshold with a selectable direction. All configuration is held static on input pins. A start pulse clears the accumulator and re-arms the trigger.

A three-state controller sequences the block:
- `ST_IDLE`: after reset; descriptors are ignored.
- `ST_ARMED`: waiting for the trigger.
- `ST_COUNT`: accumulating.

The transitions are:
- `start` moves any state to `ST_ARMED`.
- `fire` moves `ST_ARMED` to `ST_COUNT`. It happens on a valid, targeted descriptor that meets the trigger condition, or on any valid, targeted descriptor when the trigger is disabled.
- `hold` keeps the present state in every other case.

Top module: `tlpbw_counter`

## Requirements
- R1: After reset, `byte_count` is 0, and `st_armed` and `st_counting` are both 0 (state `ST_IDLE`).
- R2: A cycle with `cfg_start`=1 makes the next cycle show `byte_count`=0, `st_armed`=1 and `st_counting`=0. A descriptor presented in that same cycle is ignored.
- R3: With `cfg_tgt_sel`=0, a descriptor is targeted exactly when bit `pkt_port` of `cfg_port_mask` is 1. The requester ID is then ignored.
- R4: With `cfg_tgt_sel`=1, a descriptor is targeted exactly when `pkt_rid` equals `cfg_rid`. The port index is then ignored.
- R5: With the trigger enabled and `cfg_trig_mode`=0, the `fire` transition happens on the first targeted descriptor with `pkt_len` > 2^`cfg_trig_exp`. Earlier descriptors add nothing, and the state stays `ST_ARMED`.
- R6: With the trigger enabled and `cfg_trig_mode`=1, `fire` happens on the first targeted descriptor with `pkt_len` < 2^`cfg_trig_exp`.
- R7: With `cfg_trig_en`=0, the first targeted descriptor in `ST_ARMED` fires.
- R8: The trigger is one-shot. In `ST_COUNT`, the state stays `ST_COUNT` until the next start, whatever the lengths that follow.
- R9: The threshold filter passes descriptors by direction. With `cfg_thr_mode`=0 it passes `pkt_len` >= 2^`cfg_thr_exp`. With `cfg_thr_mode`=1 it passes `pkt_len` < 2^`cfg_thr_exp`. With `cfg_thr_en`=0 it passes every descriptor.
- R10: A descriptor is accumulated when all of the following hold:
  - it is valid and targeted;
  - it passes the threshold filter;
  - it is either seen in `ST_COUNT` or is itself the firing descriptor.

  It adds `pkt_len`×4 to `byte_count`, and the sum is visible in the cycle after the descriptor.
- R11: `byte_count` saturates at 2^`CNT_W`−1 and never wraps.
- R12: In `ST_IDLE`, descriptors have no effect on `byte_count` or on the state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_start | input | 1 | Clear the accumulator and re-arm the trigger |
| cfg_tgt_sel | input | 1 | 0: port bitmap target, 1: requester-ID target |
| cfg_port_mask | input | PORTS | Root-port bitmap |
| cfg_rid | input | RID_W | Requester ID to match |
| cfg_trig_en | input | 1 | Trigger filter enable |
| cfg_trig_mode | input | 1 | 0: length above limit, 1: length below limit |
| cfg_trig_exp | input | EXP_W | Trigger limit exponent (2^n DW) |
| cfg_thr_en | input | 1 | Threshold filter enable |
| cfg_thr_mode | input | 1 | 0: length at or above limit, 1: length below limit |
| cfg_thr_exp | input | EXP_W | Threshold limit exponent (2^n DW) |
| pkt_valid | input | 1 | Descriptor strobe |
| pkt_port | input | $clog2(PORTS) | Root-port index |
| pkt_rid | input | RID_W | Requester ID |
| pkt_len | input | LEN_W | Payload length in doublewords |
| byte_count | output | CNT_W | Saturating byte accumulator |
| st_armed | output | 1 | State is `ST_ARMED` |
| st_counting | output | 1 | State is `ST_COUNT` |

## Verification
The assertions assume that the configuration pins stay stable while descriptors arrive. They also assume that `cfg_start` is a single-cycle pulse, and that the descriptor fields are meaningful only when `pkt_valid` is high. The stimulus follows these rules:
- The bench changes configuration only in the idle gap before a start pulse.
- Descriptors are one-cycle strobes separated by an empty cycle.
- The bench drops `pkt_valid` whenever it is not presenting a descriptor.

The bench uses a 16-bit accumulator so that saturation can be reached. It sweeps every port bit, every length around each trigger and threshold limit in both directions, and a start pulse that coincides with a descriptor.

// File: rtl/tlpbw_pkg.sv
package tlpbw_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_COUNT = 2'd2
    } tlpbw_state_e;

    typedef enum logic [1:0] {
        CMP_GT = 2'd0,
        CMP_GE = 2'd1,
        CMP_LT = 2'd2
    } tlpbw_cmp_e;

endpackage

// File: rtl/tlpbw_target_match.sv
module tlpbw_target_match #(
    parameter int PORTS = 16,
    parameter int RID_W = 16,
    localparam int PORT_W = $clog2(PORTS)
) (
    input  logic              sel_rid,
    input  logic [PORTS-1:0]  port_mask,
    input  logic [RID_W-1:0]  cfg_rid,
    input  logic [PORT_W-1:0] port,
    input  logic [RID_W-1:0]  rid,
    output logic              hit
);
    logic [PORTS-1:0] port_hit;

    // R3: one decoded slot per root port, gated by its bitmap bit
    for (genvar g = 0; g < PORTS; g++) begin : g_port
        assign port_hit[g] = port_mask[g] && (port == PORT_W'(g));
    end

    // R4: exact requester-ID compare replaces the bitmap when selected
    assign hit = sel_rid ? (rid == cfg_rid) : (|port_hit);
endmodule

// File: rtl/tlpbw_len_cmp.sv
module tlpbw_len_cmp
    import tlpbw_pkg::*;
#(
    parameter int LEN_W = 11,
    parameter int EXP_W = 4,
    localparam int CMP_W = ((LEN_W > (1 << EXP_W)) ? LEN_W : (1 << EXP_W)) + 1
) (
    input  logic             en,
    input  tlpbw_cmp_e       op,
    input  logic [EXP_W-1:0] lim_exp,
    input  logic [LEN_W-1:0] len,
    output logic             pass
);
    logic [CMP_W-1:0] lim;
    logic [CMP_W-1:0] len_x;

    always_comb begin
        lim   = CMP_W'(1) << lim_exp;
        len_x = CMP_W'(len);
        if (!en) begin
            pass = 1'b1;
        end else begin
            unique case (op)
                CMP_GT:  pass = len_x >  lim;
                CMP_GE:  pass = len_x >= lim;
                CMP_LT:  pass = len_x <  lim;
                default: pass = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/tlpbw_sat_accum.sv
module tlpbw_sat_accum #(
    parameter int CNT_W = 48,
    parameter int ADD_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             add_en,
    input  logic [ADD_W-1:0] add_val,
    output logic [CNT_W-1:0] acc
);
    logic [CNT_W:0] sum;

    assign sum = {1'b0, acc} + (CNT_W + 1)'(add_val);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (clr) begin
            acc <= '0;
        end else if (add_en) begin
            // R11: clamp on carry out
            acc <= sum[CNT_W] ? '1 : sum[CNT_W-1:0];
        end
    end
endmodule

// File: rtl/tlpbw_counter.sv
module tlpbw_counter
    import tlpbw_pkg::*;
#(
    parameter int PORTS = 16,
    parameter int RID_W = 16,
    parameter int LEN_W = 11,
    parameter int EXP_W = 4,
    parameter int CNT_W = 48,
    localparam int PORT_W = $clog2(PORTS),
    localparam int ADD_W  = LEN_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_start,
    input  logic              cfg_tgt_sel,
    input  logic [PORTS-1:0]  cfg_port_mask,
    input  logic [RID_W-1:0]  cfg_rid,
    input  logic              cfg_trig_en,
    input  logic              cfg_trig_mode,
    input  logic [EXP_W-1:0]  cfg_trig_exp,
    input  logic              cfg_thr_en,
    input  logic              cfg_thr_mode,
    input  logic [EXP_W-1:0]  cfg_thr_exp,
    input  logic              pkt_valid,
    input  logic [PORT_W-1:0] pkt_port,
    input  logic [RID_W-1:0]  pkt_rid,
    input  logic [LEN_W-1:0]  pkt_len,
    output logic [CNT_W-1:0]  byte_count,
    output logic              st_armed,
    output logic              st_counting
);
    tlpbw_state_e state_q, state_d;
    logic tgt_hit, trig_pass, thr_pass, fire, add_en;

    tlpbw_target_match #(.PORTS(PORTS), .RID_W(RID_W)) u_target (
        .sel_rid   (cfg_tgt_sel),
        .port_mask (cfg_port_mask),
        .cfg_rid   (cfg_rid),
        .port      (pkt_port),
        .rid       (pkt_rid),
        .hit       (tgt_hit)
    );

    // R5 / R6 / R7: trigger compare, strict in both directions
    tlpbw_len_cmp #(.LEN_W(LEN_W), .EXP_W(EXP_W)) u_trig_cmp (
        .en      (cfg_trig_en),
        .op      (cfg_trig_mode ? CMP_LT : CMP_GT),
        .lim_exp (cfg_trig_exp),
        .len     (pkt_len),
        .pass    (trig_pass)
    );

    // R9: threshold compare, inclusive in the upward direction
    tlpbw_len_cmp #(.LEN_W(LEN_W), .EXP_W(EXP_W)) u_thr_cmp (
        .en      (cfg_thr_en),
        .op      (cfg_thr_mode ? CMP_LT : CMP_GE),
        .lim_exp (cfg_thr_exp),
        .len     (pkt_len),
        .pass    (thr_pass)
    );

    assign fire = pkt_valid && !cfg_start && tgt_hit && trig_pass
                  && (state_q == ST_ARMED);

    // R10: count in ST_COUNT or on the firing descriptor itself
    assign add_en = pkt_valid && !cfg_start && tgt_hit && thr_pass
                    && ((state_q == ST_COUNT) || fire);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (cfg_start) begin
            state_d = ST_ARMED;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_IDLE;
                ST_ARMED: state_d = fire ? ST_COUNT : ST_ARMED;
                ST_COUNT: state_d = ST_COUNT;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        st_armed    = 1'b0;
        st_counting = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_ARMED: st_armed = 1'b1;
            ST_COUNT: st_counting = 1'b1;
            default:  ;
        endcase
    end

    tlpbw_sat_accum #(.CNT_W(CNT_W), .ADD_W(ADD_W)) u_accum (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (cfg_start),
        .add_en  (add_en),
        .add_val ({pkt_len, 2'b00}),
        .acc     (byte_count)
    );

    a_r2_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_start |=> (byte_count == '0) && st_armed && !st_counting);

    a_r8_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
        (st_counting && !cfg_start) |=> st_counting);

    a_r11_never_decreases: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_start |=> byte_count >= $past(byte_count));

    a_r12_idle_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_armed && !st_counting && !cfg_start) |=>
            ($stable(byte_count) && !st_armed && !st_counting));

    a_r10_no_add_without_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (!pkt_valid && !cfg_start) |=> $stable(byte_count));
endmodule

// File: tb/tlpbw_counter_bench.sv
module tlpbw_counter_bench;
    localparam int CW = 16;
    localparam int MAXC = (1 << CW) - 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_start = 1'b0, cfg_tgt_sel = 1'b0;
    logic [15:0] cfg_port_mask = '0, cfg_rid = '0;
    logic        cfg_trig_en = 1'b0, cfg_trig_mode = 1'b0;
    logic [3:0]  cfg_trig_exp = '0;
    logic        cfg_thr_en = 1'b0, cfg_thr_mode = 1'b0;
    logic [3:0]  cfg_thr_exp = '0;
    logic        pkt_valid = 1'b0;
    logic [3:0]  pkt_port = '0;
    logic [15:0] pkt_rid = '0;
    logic [10:0] pkt_len = '0;
    logic [CW-1:0] byte_count;
    logic        st_armed, st_counting;

    int errs = 0, checks = 0;
    int m_state = 0;   // 0 idle, 1 armed, 2 counting
    int m_cnt = 0;

    always #5 clk = ~clk;

    tlpbw_counter #(.CNT_W(CW)) u_tlpbw_counter (
        .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start), .cfg_tgt_sel(cfg_tgt_sel),
        .cfg_port_mask(cfg_port_mask), .cfg_rid(cfg_rid),
        .cfg_trig_en(cfg_trig_en), .cfg_trig_mode(cfg_trig_mode), .cfg_trig_exp(cfg_trig_exp),
        .cfg_thr_en(cfg_thr_en), .cfg_thr_mode(cfg_thr_mode), .cfg_thr_exp(cfg_thr_exp),
        .pkt_valid(pkt_valid), .pkt_port(pkt_port), .pkt_rid(pkt_rid), .pkt_len(pkt_len),
        .byte_count(byte_count), .st_armed(st_armed), .st_counting(st_counting)
    );

    task automatic check(input string tag);
        checks++;
        if (byte_count !== CW'(m_cnt) || st_armed !== (m_state == 1)
            || st_counting !== (m_state == 2)) begin
            errs++;
            $display("FAIL %s: cnt=%0d armed=%0b counting=%0b expected cnt=%0d state=%0d",
                     tag, byte_count, st_armed, st_counting, m_cnt, m_state);
        end
    endtask

    function automatic void model_pkt(input int port, input int rid, input int len);
        bit tgt, trg, thr, do_add;
        int lt, lh;
        lt  = 1 << cfg_trig_exp;
        lh  = 1 << cfg_thr_exp;
        tgt = cfg_tgt_sel ? (rid == int'(cfg_rid)) : cfg_port_mask[port];
        trg = !cfg_trig_en || (cfg_trig_mode ? (len < lt) : (len > lt));
        thr = !cfg_thr_en || (cfg_thr_mode ? (len < lh) : (len >= lh));
        do_add = 1'b0;
        if (m_state == 1 && tgt && trg) begin
            m_state = 2;
            do_add = 1'b1;
        end else if (m_state == 2) begin
            do_add = 1'b1;
        end
        if (do_add && tgt && thr)
            m_cnt = (m_cnt + len * 4 > MAXC) ? MAXC : m_cnt + len * 4;
    endfunction

    task automatic start_pulse(input string tag);
        @(negedge clk);
        cfg_start = 1'b1;
        @(negedge clk);
        cfg_start = 1'b0;
        m_state = 1;
        m_cnt = 0;
        check(tag);
    endtask

    task automatic send(input int port, input int rid, input int len, input string tag);
        @(negedge clk);
        pkt_valid = 1'b1;
        pkt_port  = 4'(port);
        pkt_rid   = 16'(rid);
        pkt_len   = 11'(len);
        @(negedge clk);
        pkt_valid = 1'b0;
        model_pkt(port, rid, len);
        check(tag);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errs++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset state");
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset release");

        // R12: idle ignores descriptors
        cfg_port_mask = 16'hFFFF;
        for (int i = 0; i < 4; i++) send(i, 0, 10 + i, "R12 idle ignores");

        // R3: port bitmap sweep, filters off
        cfg_port_mask = 16'hA5C3;
        start_pulse("R2 start arms");
        for (int p = 0; p < 16; p++) send(p, 16'h3900, p + 1, "R3 port bitmap");

        // R4: requester-ID match, port ignored
        cfg_tgt_sel = 1'b1;
        cfg_rid = 16'h3900;
        cfg_port_mask = 16'h0000;
        start_pulse("R2 start clears");
        for (int p = 0; p < 16; p++) begin
            send(p, 16'h3900, 5, "R4 rid match");
            send(p, 16'h3900 ^ (1 << p), 7, "R4 rid mismatch");
        end
        cfg_tgt_sel = 1'b0;
        cfg_port_mask = 16'hFFFF;

        // R5 / R6 / R8: trigger sweeps
        cfg_trig_en = 1'b1;
        for (int md = 0; md < 2; md++) begin
            for (int e = 1; e < 5; e++) begin
                cfg_trig_mode = md[0];
                cfg_trig_exp = 4'(e);
                start_pulse("R2 re-arm");
                if (md == 0) begin
                    for (int l = 0; l <= (1 << e); l++) send(0, 0, l, "R5 below trigger");
                    send(1, 0, (1 << e) + 1, "R5 fire above");
                    send(1, 0, 1, "R8 one-shot small");
                end else begin
                    for (int l = (1 << e) + 2; l >= (1 << e); l--) send(0, 0, l, "R6 above trigger");
                    send(1, 0, (1 << e) - 1, "R6 fire below");
                    send(1, 0, 300, "R8 one-shot large");
                end
            end
        end

        // R7: trigger disabled, untargeted does not fire
        cfg_trig_en = 1'b0;
        cfg_port_mask = 16'h0002;
        start_pulse("R2 re-arm");
        send(0, 0, 9, "R7 untargeted no fire");
        send(1, 0, 9, "R7 disabled fires");
        cfg_port_mask = 16'hFFFF;

        // R9 / R10: threshold sweeps
        cfg_thr_en = 1'b1;
        for (int md = 0; md < 2; md++) begin
            for (int e = 0; e < 6; e++) begin
                cfg_thr_mode = md[0];
                cfg_thr_exp = 4'(e);
                start_pulse("R2 re-arm");
                for (int l = 0; l < 40; l++) send(l % 16, 0, l, "R9 threshold");
            end
        end
        cfg_thr_en = 1'b0;
        start_pulse("R2 re-arm");
        for (int l = 0; l < 8; l++) send(3, 0, l * 3, "R10 accumulate");

        // R10: firing descriptor counted only if threshold passes
        cfg_trig_en = 1'b1; cfg_trig_mode = 1'b0; cfg_trig_exp = 4'd2;
        cfg_thr_en = 1'b1; cfg_thr_mode = 1'b1; cfg_thr_exp = 4'd3;
        start_pulse("R2 re-arm");
        send(0, 0, 5, "R10 fire counted");
        start_pulse("R2 re-arm");
        send(0, 0, 9, "R10 fire not counted");
        send(0, 0, 2, "R10 after fire");
        cfg_trig_en = 1'b0; cfg_thr_en = 1'b0;

        // R11: saturation
        start_pulse("R2 re-arm");
        for (int i = 0; i < 10; i++) send(i, 0, 2047, "R11 saturation");

        // R2: start with concurrent descriptor
        @(negedge clk);
        cfg_start = 1'b1;
        pkt_valid = 1'b1;
        pkt_port = 4'd1;
        pkt_len = 11'd50;
        @(negedge clk);
        cfg_start = 1'b0;
        pkt_valid = 1'b0;
        m_state = 1;
        m_cnt = 0;
        check("R2 start beats descriptor");
        send(1, 0, 50, "R2 counts after start");

        finish_run();
    end
endmodule